// File: doc/BRIEF.md
# Staged PLL Control Register File

This block keeps the control words for a clock generator. It sits on a simple one-cycle write strobe and holds three 64-bit registers: a PLL control word and two registers for a random-number source, one for control and one for data. Writes to the two random-number registers take effect at once. Writes to the PLL control address go only into a staging copy. The live copy, whose divider fields feed the clock generator, picks up the staged value when the PLL's active-low reset is released.

The PLL reset input passes through a synchroniser and a rising-edge detector. The detector produces a single-cycle commit pulse. At that commit, an optional bypass input replaces the second and fourth divider fields with fixed stand-in values, which are set by parameters. A mode output is raised whenever either of the two test-mode bits in the live word is set.

Top module: `pll_cfg_regfile`

## Requirements
- R1: After synchronous reset, the live and staged PLL words both equal the parameter PLL_INIT (default 0x2011C0: div1=0, div2=7, div3=1, div4=8). Both random-number registers are zero.
- R2: A write (wr_vld=1, wr_is_write=1) to the PLL address (default 0x00) changes the staged word on the next clock. The live word keeps its value.
- R3: A write to the random-number control address (default 0x20) or the data address (default 0x28) loads that register on the next clock.
- R4: A request with wr_is_write=0, or a write to any address other than the three decoded ones, leaves all four register outputs unchanged.
- R5: A rising edge on pll_rst_n copies the staged word into the live word on the third clock edge after the rise. The live word is still unchanged after the second edge. A falling edge on pll_rst_n commits nothing.
- R6: If byp_en is high at the commit, the live div2 field [11:6] becomes BYP_DIV2 (default 0x07) and the live div4 field [24:18] becomes BYP_DIV4 (default 0x08). All other bits come from the staged word.
- R7: test_mode is high exactly when bit 25 or bit 26 of the live word is set. A change that is only staged does not change test_mode.
- R8: Bits [63:28] of a word written to the PLL address are stored as zero.
- R9: If a PLL write lands in the same cycle as a commit, the commit takes the previous staged value. The new value remains staged for the next commit.
- R10: The outputs div1, div2, div3 and div4 equal bits [5:0], [11:6], [17:12] and [24:18] of the live word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_vld | input | 1 | Request strobe, one cycle |
| wr_is_write | input | 1 | 1 = write request, 0 = read request (ignored) |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 64 | Write data |
| pll_rst_n | input | 1 | Active-low PLL reset; its release commits |
| byp_en | input | 1 | Apply bypass stand-in values at commit |
| pll_ctl_act | output | 64 | Live PLL control word |
| pll_ctl_stg | output | 64 | Staged PLL control word |
| rng_ctl | output | 64 | Random-number control register |
| rng_data | output | 64 | Random-number data register |
| div1 | output | 6 | Live div1 field |
| div2 | output | 6 | Live div2 field |
| div3 | output | 6 | Live div3 field |
| div4 | output | 7 | Live div4 field |
| test_mode | output | 1 | Test-mode flag |

## Verification
Writes go to each decoded address, to an undecoded address, and to the PLL address as read-type requests. These cases separate a correct decoder from one that ignores the address or the request type. Commits are run with bypass off and with bypass on, using staged dividers that differ from the stand-in values, so an override that fails to apply, or that hits the wrong field, shows up. The live word is sampled one edge before the commit edge and again on it, which catches a synchroniser that is too short or too long. A falling reset edge and a write that arrives in the commit cycle test the edge polarity and the old-value rule. Test-mode words that set bit 25 alone and then bit 26 alone show that each bit drives the mode flag on its own.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int CW      = 64;
    localparam int D1_LO   = 0;
    localparam int D1_W    = 6;
    localparam int D2_LO   = 6;
    localparam int D2_W    = 6;
    localparam int D3_LO   = 12;
    localparam int D3_W    = 6;
    localparam int D4_LO   = 18;
    localparam int D4_W    = 7;
    localparam int TM1_BIT = 25;
    localparam int TM2_BIT = 26;
    localparam int CHG_BIT = 27;
    localparam int USED_W  = CHG_BIT + 1;
    localparam logic [CW-1:0] USED_MASK = {{(CW-USED_W){1'b0}}, {USED_W{1'b1}}};

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_PLL   = 2'd1,
        TGT_RCTL  = 2'd2,
        TGT_RDATA = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        logic [CW-1:0] stage;
        logic [CW-1:0] active;
    } pll_pair_t;

    typedef struct packed {
        logic [CW-1:0] ctl;
        logic [CW-1:0] data;
    } rng_pair_t;

endpackage

// File: rtl/pll_wr_decode.sv
module pll_wr_decode
    import pll_cfg_pkg::*;
#(
    parameter int               ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] PLL_ADDR   = 8'h00,
    parameter logic [ADDR_W-1:0] RCTL_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] RDATA_ADDR = 8'h28
) (
    input  logic              wr_vld,
    input  logic              wr_is_write,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_tgt_e           tgt
);

    always_comb begin
        tgt = TGT_NONE;
        if (wr_vld && wr_is_write) begin
            if (wr_addr == PLL_ADDR) begin
                tgt = TGT_PLL;
            end else if (wr_addr == RCTL_ADDR) begin
                tgt = TGT_RCTL;
            end else if (wr_addr == RDATA_ADDR) begin
                tgt = TGT_RDATA;
            end
        end
    end

endmodule

// File: rtl/pll_rst_edge.sv
module pll_rst_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pll_rst_n,
    output logic commit
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[TOP-1:0], pll_rst_n};
        st_d.prev  = st_q.chain[TOP];
        commit     = st_q.chain[TOP] & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{chain: {SYNC_STAGES{1'b1}}, prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pll_ctl_stage.sv
module pll_ctl_stage
    import pll_cfg_pkg::*;
#(
    parameter logic [CW-1:0]   PLL_INIT = 64'h0000_0000_0020_11C0,
    parameter logic [D2_W-1:0] BYP_DIV2 = 6'h07,
    parameter logic [D4_W-1:0] BYP_DIV4 = 7'h08
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          commit,
    input  logic          byp_en,
    output logic [CW-1:0] stage_q,
    output logic [CW-1:0] active_q
);

    localparam logic [CW-1:0] INIT_CLEAN = PLL_INIT & USED_MASK;

    pll_pair_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (commit) begin
            pr_d.active = pr_q.stage;
            if (byp_en) begin
                pr_d.active[D2_LO +: D2_W] = BYP_DIV2;
                pr_d.active[D4_LO +: D4_W] = BYP_DIV4;
            end
        end
        if (wr_en) begin
            pr_d.stage = wr_data & USED_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_q <= '{stage: INIT_CLEAN, active: INIT_CLEAN};
        end else begin
            pr_q <= pr_d;
        end
    end

    assign stage_q  = pr_q.stage;
    assign active_q = pr_q.active;

endmodule

// File: rtl/rng_regs.sv
module rng_regs
    import pll_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wr_tgt_e       tgt,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] ctl_q,
    output logic [CW-1:0] data_q
);

    rng_pair_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        case (tgt)
            TGT_RCTL:  rg_d.ctl  = wr_data;
            TGT_RDATA: rg_d.data = wr_data;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ctl_q  = rg_q.ctl;
    assign data_q = rg_q.data;

endmodule

// File: rtl/pll_cfg_regfile.sv
module pll_cfg_regfile
    import pll_cfg_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] PLL_ADDR    = 8'h00,
    parameter logic [ADDR_W-1:0] RCTL_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] RDATA_ADDR  = 8'h28,
    parameter int                SYNC_STAGES = 2,
    parameter logic [63:0]       PLL_INIT    = 64'h0000_0000_0020_11C0,
    parameter logic [5:0]        BYP_DIV2    = 6'h07,
    parameter logic [6:0]        BYP_DIV4    = 7'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic              wr_is_write,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic              pll_rst_n,
    input  logic              byp_en,
    output logic [63:0]       pll_ctl_act,
    output logic [63:0]       pll_ctl_stg,
    output logic [63:0]       rng_ctl,
    output logic [63:0]       rng_data,
    output logic [5:0]        div1,
    output logic [5:0]        div2,
    output logic [5:0]        div3,
    output logic [6:0]        div4,
    output logic              test_mode
);

    wr_tgt_e tgt_w;
    logic    commit_w;

    pll_wr_decode #(
        .ADDR_W    (ADDR_W),
        .PLL_ADDR  (PLL_ADDR),
        .RCTL_ADDR (RCTL_ADDR),
        .RDATA_ADDR(RDATA_ADDR)
    ) u_dec (
        .wr_vld     (wr_vld),
        .wr_is_write(wr_is_write),
        .wr_addr    (wr_addr),
        .tgt        (tgt_w)
    );

    pll_rst_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pll_rst_n(pll_rst_n),
        .commit   (commit_w)
    );

    pll_ctl_stage #(
        .PLL_INIT(PLL_INIT),
        .BYP_DIV2(BYP_DIV2),
        .BYP_DIV4(BYP_DIV4)
    ) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tgt_w == TGT_PLL),
        .wr_data (wr_data),
        .commit  (commit_w),
        .byp_en  (byp_en),
        .stage_q (pll_ctl_stg),
        .active_q(pll_ctl_act)
    );

    rng_regs u_rng (
        .clk    (clk),
        .rst    (rst),
        .tgt    (tgt_w),
        .wr_data(wr_data),
        .ctl_q  (rng_ctl),
        .data_q (rng_data)
    );

    always_comb begin
        div1      = pll_ctl_act[D1_LO +: D1_W];
        div2      = pll_ctl_act[D2_LO +: D2_W];
        div3      = pll_ctl_act[D3_LO +: D3_W];
        div4      = pll_ctl_act[D4_LO +: D4_W];
        test_mode = pll_ctl_act[TM1_BIT] | pll_ctl_act[TM2_BIT];
    end

endmodule

// File: rtl/pll_cfg_regfile_chk.sv
module pll_cfg_regfile_chk #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] PLL_ADDR   = 8'h00,
    parameter logic [ADDR_W-1:0] RCTL_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] RDATA_ADDR = 8'h28,
    parameter logic [5:0]        BYP_DIV2   = 6'h07,
    parameter logic [6:0]        BYP_DIV4   = 7'h08
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_vld,
    input logic              wr_is_write,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [63:0]       wr_data,
    input logic              byp_en,
    input logic              commit,
    input logic [63:0]       stage,
    input logic [63:0]       active,
    input logic [63:0]       rng_ctl,
    input logic [63:0]       rng_data,
    input logic              test_mode
);

    p_stage_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_is_write && wr_addr == PLL_ADDR)
        |=> stage[27:0] == $past(wr_data[27:0]));

    p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    p_rng_ctl_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_is_write && wr_addr == RCTL_ADDR)
        |=> rng_ctl == $past(wr_data));

    p_rng_data_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_is_write && wr_addr == RDATA_ADDR)
        |=> rng_data == $past(wr_data));

    p_read_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && !wr_is_write)
        |=> ($stable(stage) && $stable(rng_ctl) && $stable(rng_data)));

    p_commit_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // covers R9 too: the copy uses the staged value from before the edge
    p_commit_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (commit && !byp_en) |=> active == $past(stage));

    p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        (commit && byp_en)
        |=> (active[11:6] == BYP_DIV2 && active[24:18] == BYP_DIV4
             && active[5:0] == $past(stage[5:0])
             && active[17:12] == $past(stage[17:12])));

    p_mode_after_commit_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(test_mode) |-> $past(commit));

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        stage[63:28] == '0);

endmodule

bind pll_cfg_regfile pll_cfg_regfile_chk #(
    .ADDR_W    (ADDR_W),
    .PLL_ADDR  (PLL_ADDR),
    .RCTL_ADDR (RCTL_ADDR),
    .RDATA_ADDR(RDATA_ADDR),
    .BYP_DIV2  (BYP_DIV2),
    .BYP_DIV4  (BYP_DIV4)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_vld     (wr_vld),
    .wr_is_write(wr_is_write),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .byp_en     (byp_en),
    .commit     (commit_w),
    .stage      (pll_ctl_stg),
    .active     (pll_ctl_act),
    .rng_ctl    (rng_ctl),
    .rng_data   (rng_data),
    .test_mode  (test_mode)
);

// File: tb/pll_cfg_regfile_bench.sv
module pll_cfg_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] INIT = 64'h0000_0000_0020_11C0;
    localparam logic [7:0] A_PLL = 8'h00, A_RCTL = 8'h20, A_RDATA = 8'h28, A_NONE = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_vld = 1'b0, wr_is_write = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        pll_rst_n = 1'b0, byp_en = 1'b0;
    logic [63:0] pll_ctl_act, pll_ctl_stg, rng_ctl, rng_data;
    logic [5:0]  div1, div2, div3;
    logic [6:0]  div4;
    logic        test_mode;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [63:0] act, stg, rc, rd;
    } exp_t;

    exp_t exp_q[$];
    event exp_ev;

    logic [63:0] m_act = INIT, m_stg = INIT, m_rc = '0, m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_cfg_regfile u_pll_cfg_regfile (
        .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_is_write(wr_is_write),
        .wr_addr(wr_addr), .wr_data(wr_data), .pll_rst_n(pll_rst_n), .byp_en(byp_en),
        .pll_ctl_act(pll_ctl_act), .pll_ctl_stg(pll_ctl_stg), .rng_ctl(rng_ctl),
        .rng_data(rng_data), .div1(div1), .div2(div2), .div3(div3), .div4(div4),
        .test_mode(test_mode)
    );

    task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them to the outputs
    initial begin
        forever begin
            @(exp_ev);
            while (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "live word", pll_ctl_act, e.act);
                cmp(e.tag, "staged word", pll_ctl_stg, e.stg);
                cmp(e.tag, "rng ctl", rng_ctl, e.rc);
                cmp(e.tag, "rng data", rng_data, e.rd);
                cmp({e.tag, "/R7"}, "test_mode", {63'd0, test_mode},
                    {63'd0, e.act[25] | e.act[26]});
                cmp({e.tag, "/R10"}, "dividers", {37'd0, div4, div3, div2, div1},
                    {37'd0, e.act[24:18], e.act[17:12], e.act[11:6], e.act[5:0]});
            end
        end
    end

    task automatic expect_now(string tag);
        exp_t e;
        e.tag = tag; e.act = m_act; e.stg = m_stg; e.rc = m_rc; e.rd = m_rd;
        exp_q.push_back(e);
        ->exp_ev;
        #1;
    endtask

    task automatic req(bit is_wr, logic [7:0] a, logic [63:0] d);
        @(negedge clk);
        wr_vld = 1'b1; wr_is_write = is_wr; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_vld = 1'b0; wr_is_write = 1'b0;
        if (is_wr) begin
            if (a == A_PLL)   m_stg = d & 64'h0000_0000_0FFF_FFFF;
            if (a == A_RCTL)  m_rc  = d;
            if (a == A_RDATA) m_rd  = d;
        end
    endtask

    function automatic logic [63:0] with_byp(logic [63:0] v);
        logic [63:0] r = v;
        r[11:6]  = 6'h07;
        r[24:18] = 7'h08;
        return r;
    endfunction

    task automatic pll_low();
        @(negedge clk); pll_rst_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // release, check one edge early (unchanged) and on the commit edge
    task automatic pll_release(string tag);
        @(negedge clk); pll_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_now({tag, " pre-commit"});
        @(negedge clk);
        m_act = byp_en ? with_byp(m_stg) : m_stg;
        expect_now({tag, " commit"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1 reset");

        req(1, A_PLL, 64'hDEAD_BEEF_0123_4567);
        expect_now("R2/R8 staged write");

        req(1, A_RCTL, 64'h1111_2222_3333_4444);
        expect_now("R3 rng ctl");
        req(1, A_RDATA, 64'h5555_6666_7777_8888);
        expect_now("R3 rng data");

        req(1, A_NONE, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_now("R4 other address");
        req(0, A_PLL, 64'h0000_0000_0AAA_AAAA);
        expect_now("R4 read to pll");
        req(0, A_RCTL, 64'h0);
        expect_now("R4 read to rng ctl");

        pll_release("R5 plain");

        req(1, A_PLL, INIT | 64'h0400_0000);
        expect_now("R7 staged only");
        pll_low();
        expect_now("R5 falling edge");
        pll_release("R7 bit26");
        req(1, A_PLL, INIT | 64'h0200_0000);
        pll_low();
        pll_release("R7 bit25");

        byp_en = 1'b1;
        req(1, A_PLL, 64'h0000_0000_0184_5A83);
        pll_low();
        pll_release("R6 bypass");
        byp_en = 1'b0;

        req(1, A_PLL, 64'h0000_0000_0013_3333);
        pll_low();
        @(negedge clk); pll_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        wr_vld = 1'b1; wr_is_write = 1'b1; wr_addr = A_PLL; wr_data = 64'h0000_0000_0066_6666;
        @(negedge clk);
        wr_vld = 1'b0; wr_is_write = 1'b0;
        m_act = m_stg;
        m_stg = 64'h0000_0000_0066_6666;
        expect_now("R9 write in commit cycle");
        pll_low();
        pll_release("R9 second commit");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule